// File: doc/BRIEF.md
# Memory-Card Command Issue Unit

This block turns a register-level command write into one request toward a memory card and records the card's answer. Software first loads a 32-bit argument and then writes a command word. That word holds a 6-bit command index and a few control flags. When the word has its enable flag set and its pending flag clear, and no earlier command is still running, the unit presents the index and the latched argument on a card-side valid/ready port. It then waits for a single reply beat.

The reply carries a byte-length code, sixteen response bytes and an error flag. The unit checks the length against the form the command asked for. A matching reply is packed big-endian into four 32-bit response words. A mismatch or an error becomes a timeout. Each outcome sets one sticky status bit, and software clears these bits with a mask. The enable flag never stays set in the stored command word. The interrupt-wait and pending modes are not implemented; a command that selects either of them raises a one-cycle unsupported flag.

Top module: `card_cmd_issuer`

## Requirements
- R1: After reset, argReg, cmdReg, status and respWords are all zero, and reqValid and unsupFlag are low.
- R2: cmdWrData fields are: bits [5:0] command index, bit 6 response expected, bit 7 long response, bit 8 interrupt-wait, bit 9 pending, bit 10 enable. An accepted write shows in cmdReg on the next cycle with bit 10 forced to 0, and cmdReg bit 10 is never 1.
- R3: A command write taken while idle, with bit 10 set and bit 9 clear, raises reqValid on the next cycle. reqIndex carries the written index and reqArg carries argReg. Both stay stable until reqReady is seen. status bit 11 (command active) is high from that cycle until the reply is taken.
- R4: A command write while status bit 11 is high is ignored: cmdReg keeps its value and no new request is made.
- R5: An accepted write with bit 10 set and bit 8 or bit 9 set pulses unsupFlag for one cycle. With bit 9 set, no request is made and status and respWords are unchanged. With only bit 8 set, the command is still issued.
- R6: For a command with bit 6 clear, an error-free reply sets status bit 7 and leaves respWords unchanged, whatever its length code.
- R7: status bit 2 (timeout) is set, and respWords are left unchanged, when the reply has rspErr high. It is also set when bit 6 was set and the length code is 0, or is 4 with bit 7 set, or is anything other than 4 or 16.
- R8: A 4-byte reply to a command with bit 6 set and bit 7 clear sets status bit 6. It loads word 0 (respWords[31:0]) from rspData[127:96], where the first byte rspData[127:120] lands in bits [31:24]. Words 1 to 3 are cleared.
- R9: A 16-byte reply to a command with bit 6 set loads word i (respWords[32i+31:32i]) from rspData[127-32i -: 32] for i = 0..3, with bit 0 of word 3 forced to 0, and sets status bit 6.
- R10: Status bits 2, 6 and 7 are sticky. statClrEn clears those of them whose statClrMask bit is 1. A bit being set in the same cycle wins over its clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| argWrEn | input | 1 | Write strobe for the argument register |
| argWrData | input | 32 | Argument value |
| cmdWrEn | input | 1 | Write strobe for the command register |
| cmdWrData | input | 11 | Command word (index and flags) |
| statClrEn | input | 1 | Status clear strobe |
| statClrMask | input | 12 | Status bits to clear |
| argReg | output | 32 | Stored argument |
| cmdReg | output | 11 | Stored command word, enable always 0 |
| status | output | 12 | Bit 2 timeout, bit 6 response, bit 7 sent, bit 11 active |
| unsupFlag | output | 1 | One-cycle pulse for an unsupported mode |
| reqValid | output | 1 | Card request valid |
| reqReady | input | 1 | Card request accepted |
| reqIndex | output | 6 | Command index toward the card |
| reqArg | output | 32 | Argument toward the card |
| rspValid | input | 1 | Reply beat valid |
| rspLen | input | 5 | Reply length in bytes |
| rspData | input | 128 | Reply bytes, first byte in the top bits |
| rspErr | input | 1 | Card reported an error |
| respWords | output | 128 | Four response words, word 0 lowest |

## Verification
The bench aims at the length-check corners: a 4-byte reply to a long command, a 16-byte reply to a short one, and odd lengths such as 3 or 8. A design that trusted the length code would overwrite the response words or report success where a timeout is due. It also checks bit 0 of the last long word and the zeroing of words 1 to 3 on a short reply. An off-by-one in word placement, or a missing clear, shows up directly in respWords. Other targets are the pending and interrupt-wait flags, a command write while busy, and a status clear colliding with a set; a design that got any of these wrong would issue a stray request, lose a command or drop a completion bit.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;
  localparam int CMD_W     = 11;
  localparam int B_RSP     = 6;
  localparam int B_LONG    = 7;
  localparam int B_IRQW    = 8;
  localparam int B_PEND    = 9;
  localparam int B_EN      = 10;
  localparam int STAT_W    = 12;
  localparam int S_TMO     = 2;
  localparam int S_RSP     = 6;
  localparam int S_SENT    = 7;
  localparam int S_ACT     = 11;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} issueState_t;

  typedef struct packed {
    logic issue;
    logic capShort;
    logic capLong;
  } dpStrobe_t;
endpackage

// File: rtl/card_cmd_ctrl.sv
module card_cmd_ctrl
  import card_cmd_pkg::*;
#(
  parameter int LEN_W       = 5,
  parameter int SHORT_BYTES = 4,
  parameter int LONG_BYTES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrData,
  input  logic              statClrEn,
  input  logic [STAT_W-1:0] statClrMask,
  input  logic              reqReady,
  input  logic              rspValid,
  input  logic [LEN_W-1:0]  rspLen,
  input  logic              rspErr,
  output logic [CMD_W-1:0]  cmdReg,
  output logic [STAT_W-1:0] status,
  output logic              unsupFlag,
  output logic              reqValid,
  output dpStrobe_t         strobe
);
  localparam logic [STAT_W-1:0] STICKY =
    (STAT_W'(1) << S_TMO) | (STAT_W'(1) << S_RSP) | (STAT_W'(1) << S_SENT);
  localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(SHORT_BYTES);
  localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(LONG_BYTES);

  issueState_t state;
  logic        expectRsp, expectLong;
  logic [STAT_W-1:0] sticky;
  logic        idle, wrTaken, wrIssue, done, tmo, rspOk;
  logic [STAT_W-1:0] setBits;

  assign idle    = (state == ST_IDLE);
  assign wrTaken = cmdWrEn && idle;
  assign wrIssue = wrTaken && cmdWrData[B_EN] && !cmdWrData[B_PEND];
  assign done    = (state == ST_WAIT) && rspValid;

  always_comb begin
    tmo = rspErr;
    if (expectRsp) begin
      if (rspLen == '0) tmo = 1'b1;
      if (rspLen == LEN_SHORT && expectLong) tmo = 1'b1;
      if (rspLen != LEN_SHORT && rspLen != LEN_LONG) tmo = 1'b1;
    end
    rspOk = expectRsp && !tmo;
  end

  always_comb begin
    strobe.issue    = wrIssue;
    strobe.capShort = done && rspOk && (rspLen == LEN_SHORT);
    strobe.capLong  = done && rspOk && (rspLen == LEN_LONG);
  end

  always_comb begin
    setBits = '0;
    if (done) begin
      setBits[S_TMO]  = tmo;
      setBits[S_RSP]  = rspOk;
      setBits[S_SENT] = !expectRsp && !tmo;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cmdReg     <= '0;
      expectRsp  <= 1'b0;
      expectLong <= 1'b0;
      unsupFlag  <= 1'b0;
      sticky     <= '0;
    end else begin
      unsupFlag <= wrTaken && cmdWrData[B_EN] && (cmdWrData[B_IRQW] || cmdWrData[B_PEND]);
      if (wrTaken) begin
        cmdReg       <= cmdWrData;
        cmdReg[B_EN] <= 1'b0;
      end
      if (wrIssue) begin
        expectRsp  <= cmdWrData[B_RSP];
        expectLong <= cmdWrData[B_LONG];
      end
      sticky <= ((sticky & ~(statClrEn ? (statClrMask & STICKY) : '0)) | setBits) & STICKY;
      case (state)
        ST_IDLE: if (wrIssue)  state <= ST_REQ;
        ST_REQ:  if (reqReady) state <= ST_WAIT;
        ST_WAIT: if (rspValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    status        = sticky;
    status[S_ACT] = !idle;
  end
  assign reqValid = (state == ST_REQ);
endmodule

// File: rtl/card_cmd_dpath.sv
module card_cmd_dpath
  import card_cmd_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int WORD_W = 32,
  parameter int NWORDS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     argWrEn,
  input  logic [ARG_W-1:0]         argWrData,
  input  logic [IDX_W-1:0]         cmdIndex,
  input  dpStrobe_t                strobe,
  input  logic [NWORDS*WORD_W-1:0] rspData,
  output logic [ARG_W-1:0]         argReg,
  output logic [IDX_W-1:0]         reqIndex,
  output logic [ARG_W-1:0]         reqArg,
  output logic [NWORDS*WORD_W-1:0] respWords
);
  localparam int TOTAL_W = NWORDS * WORD_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      argReg   <= '0;
      reqIndex <= '0;
      reqArg   <= '0;
    end else begin
      if (argWrEn) argReg <= argWrData;
      if (strobe.issue) begin
        reqIndex <= cmdIndex;
        reqArg   <= argReg;
      end
    end
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic [WORD_W-1:0] beWord;
    always_comb begin
      beWord = rspData[TOTAL_W-1-WORD_W*i -: WORD_W];
      if (i == NWORDS-1) beWord[0] = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        respWords[WORD_W*i +: WORD_W] <= '0;
      end else if (strobe.capLong) begin
        respWords[WORD_W*i +: WORD_W] <= beWord;
      end else if (strobe.capShort) begin
        if (i == 0) respWords[WORD_W*i +: WORD_W] <= rspData[TOTAL_W-1 -: WORD_W];
        else        respWords[WORD_W*i +: WORD_W] <= '0;
      end
    end
  end
endmodule

// File: rtl/card_cmd_issuer.sv
module card_cmd_issuer
  import card_cmd_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int LEN_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     argWrEn,
  input  logic [ARG_W-1:0]         argWrData,
  input  logic                     cmdWrEn,
  input  logic [CMD_W-1:0]         cmdWrData,
  input  logic                     statClrEn,
  input  logic [STAT_W-1:0]        statClrMask,
  output logic [ARG_W-1:0]         argReg,
  output logic [CMD_W-1:0]         cmdReg,
  output logic [STAT_W-1:0]        status,
  output logic                     unsupFlag,
  output logic                     reqValid,
  input  logic                     reqReady,
  output logic [IDX_W-1:0]         reqIndex,
  output logic [ARG_W-1:0]         reqArg,
  input  logic                     rspValid,
  input  logic [LEN_W-1:0]         rspLen,
  input  logic [NWORDS*WORD_W-1:0] rspData,
  input  logic                     rspErr,
  output logic [NWORDS*WORD_W-1:0] respWords
);
  localparam int SHORT_BYTES = WORD_W / 8;
  localparam int LONG_BYTES  = NWORDS * WORD_W / 8;

  dpStrobe_t strobe;

  card_cmd_ctrl #(
    .LEN_W(LEN_W), .SHORT_BYTES(SHORT_BYTES), .LONG_BYTES(LONG_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .statClrEn(statClrEn), .statClrMask(statClrMask),
    .reqReady(reqReady), .rspValid(rspValid), .rspLen(rspLen), .rspErr(rspErr),
    .cmdReg(cmdReg), .status(status), .unsupFlag(unsupFlag),
    .reqValid(reqValid), .strobe(strobe)
  );

  card_cmd_dpath #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .WORD_W(WORD_W), .NWORDS(NWORDS)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .argWrEn(argWrEn), .argWrData(argWrData),
    .cmdIndex(cmdWrData[IDX_W-1:0]), .strobe(strobe), .rspData(rspData),
    .argReg(argReg), .reqIndex(reqIndex), .reqArg(reqArg), .respWords(respWords)
  );
endmodule

// File: rtl/card_cmd_issuer_chk.sv
module card_cmd_issuer_chk
  import card_cmd_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int WORD_W = 32,
  parameter int NWORDS = 4
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     cmdWrEn,
  input logic [CMD_W-1:0]         cmdWrData,
  input logic                     statClrEn,
  input logic [STAT_W-1:0]        statClrMask,
  input logic [CMD_W-1:0]         cmdReg,
  input logic [STAT_W-1:0]        status,
  input logic                     reqValid,
  input logic                     reqReady,
  input logic [IDX_W-1:0]         reqIndex,
  input logic [ARG_W-1:0]         reqArg,
  input logic                     rspValid,
  input logic                     rspErr,
  input logic [NWORDS*WORD_W-1:0] respWords
);
  localparam int LAST_LSB = (NWORDS - 1) * WORD_W;

  AST_ENABLE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    !cmdReg[B_EN]); // R2

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqIndex) && $stable(reqArg)); // R3

  AST_REQ_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> status[S_ACT]); // R3

  AST_PEND_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    cmdWrEn && cmdWrData[B_EN] && cmdWrData[B_PEND] && !status[S_ACT] |=> !reqValid && !status[S_ACT]); // R5

  AST_TMO_KEEPS_WORDS: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspErr && status[S_ACT] && !reqValid |=> $stable(respWords)); // R7

  AST_LAST_BIT0: assert property (@(posedge clk) disable iff (!rstN)
    !respWords[LAST_LSB]); // R9

  AST_RSP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    status[S_RSP] && !(statClrEn && statClrMask[S_RSP]) |=> status[S_RSP]); // R10
endmodule

bind card_cmd_issuer card_cmd_issuer_chk u_chk (.*);

// File: tb/card_cmd_issuer_bench.sv
module card_cmd_issuer_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         argWrEn = 0, cmdWrEn = 0, statClrEn = 0;
  logic [31:0]  argWrData = '0;
  logic [10:0]  cmdWrData = '0;
  logic [11:0]  statClrMask = '0;
  logic [31:0]  argReg, reqArg;
  logic [10:0]  cmdReg;
  logic [11:0]  status;
  logic         unsupFlag, reqValid, reqReady = 0, rspValid = 0, rspErr = 0;
  logic [5:0]   reqIndex;
  logic [4:0]   rspLen = '0;
  logic [127:0] rspData = '0, respWords;

  int nChecks = 0, nFails = 0;
  logic [11:0]  expStat = '0;
  logic [127:0] expWords = '0;

  always #4 clk = ~clk;

  card_cmd_issuer u_card_cmd_issuer (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 = sent, 1 = response captured, 2 = timeout
  function automatic int classify(input bit rspE, input bit lng, input int len, input bit err);
    if (err) return 2;
    if (!rspE) return 0;
    if (len == 4 && !lng) return 1;
    if (len == 16) return 1;
    return 2;
  endfunction

  function automatic logic [127:0] packWords(input logic [127:0] d, input int len);
    logic [127:0] w = '0;
    if (len == 4) w[31:0] = d[127:96];
    else begin
      for (int i = 0; i < 4; i++) w[32*i +: 32] = d[127-32*i -: 32];
      w[96] = 1'b0;
    end
    return w;
  endfunction

  task automatic runCmd(input logic [5:0] idx, input bit rspE, input bit lng, input bit irqw,
                        input logic [31:0] arg, input int len, input logic [127:0] data,
                        input bit err, input int dly, input bit clrAtDone, input logic [11:0] clrMask);
    logic [10:0] cw;
    int kind;
    string tag;
    cw = {1'b1, 1'b0, irqw, lng, rspE, idx};
    @(negedge clk); argWrEn = 1; argWrData = arg;
    @(negedge clk); argWrEn = 0; cmdWrEn = 1; cmdWrData = cw;
    @(negedge clk); cmdWrEn = 0;
    chk("R3 reqValid", reqValid, 1);
    chk("R3 reqIndex", reqIndex, idx);
    chk("R3 reqArg", reqArg, arg);
    chk("R3 active", status[11], 1);
    chk("R2 cmdReg", cmdReg, cw & ~11'h400);
    chk("R5 unsupFlag", unsupFlag, irqw);
    for (int k = 0; k < dly; k++) begin
      @(negedge clk);
      chk("R3 held", {reqValid, reqIndex, reqArg}, {1'b1, idx, arg});
    end
    reqReady = 1;
    @(negedge clk); reqReady = 0;
    chk("R3 req done", {reqValid, status[11]}, 2'b01);
    rspValid = 1; rspLen = 5'(len); rspData = data; rspErr = err;
    statClrEn = clrAtDone; statClrMask = clrMask;
    @(negedge clk); rspValid = 0; rspErr = 0; statClrEn = 0;
    if (clrAtDone) expStat &= ~(clrMask & 12'h0C4);
    kind = classify(rspE, lng, len, err);
    if (kind == 2) begin expStat[2] = 1; tag = "R7"; end
    else if (kind == 0) begin expStat[7] = 1; tag = "R6"; end
    else begin
      expStat[6] = 1; expWords = packWords(data, len);
      tag = (len == 4) ? "R8" : "R9";
    end
    chk({tag, " status"}, status, expStat);
    chk({tag, " words"}, respWords, expWords);
  endtask

  task automatic clearStat(input logic [11:0] m);
    @(negedge clk); statClrEn = 1; statClrMask = m;
    @(negedge clk); statClrEn = 0;
    expStat &= ~(m & 12'h0C4);
    chk("R10 clear", status, expStat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R3 watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [127:0] pat;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset regs", {argReg, cmdReg, status}, '0);
    chk("R1 reset words", respWords, '0);
    chk("R1 reset flags", {reqValid, unsupFlag}, 2'b00);

    pat = 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F11;
    // short response, first byte on top
    runCmd(6'd17, 1, 0, 0, 32'hDEAD_BEEF, 4, pat, 0, 2, 0, '0);
    // long response, word 3 bit 0 forced low
    runCmd(6'd2, 1, 1, 0, 32'h1, 16, pat, 0, 0, 0, '0);
    // short asked, 16 returned: captured as long
    runCmd(6'd9, 1, 0, 0, 32'h2, 16, ~pat, 0, 1, 0, '0);
    // short response then clears words 1..3
    runCmd(6'd3, 1, 0, 0, 32'h3, 4, pat, 0, 0, 0, '0);
    // timeouts: long asked with 4 bytes, zero length, odd length, error
    runCmd(6'd4, 1, 1, 0, 32'h4, 4, ~pat, 0, 0, 0, '0);
    runCmd(6'd5, 1, 0, 0, 32'h5, 0, ~pat, 0, 0, 0, '0);
    runCmd(6'd6, 1, 0, 0, 32'h6, 8, ~pat, 0, 0, 0, '0);
    runCmd(6'd7, 0, 0, 0, 32'h7, 4, ~pat, 1, 0, 0, '0);
    // no response expected
    runCmd(6'd0, 0, 0, 0, 32'h8, 16, ~pat, 0, 0, 0, '0);
    // interrupt-wait only: flagged yet issued
    runCmd(6'd12, 1, 0, 1, 32'h9, 4, pat, 0, 0, 0, '0);
    // clear collides with set of bit 6: set wins
    runCmd(6'd13, 1, 0, 0, 32'hA, 4, pat, 0, 0, 1, 12'hFFF);
    clearStat(12'h004);
    clearStat(12'hFFF);

    // pending mode: no issue, state kept
    @(negedge clk); cmdWrEn = 1; cmdWrData = {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'd21};
    @(negedge clk); cmdWrEn = 0;
    chk("R5 pending no req", {reqValid, status[11]}, 2'b00);
    chk("R5 pending flag", unsupFlag, 1);
    chk("R5 pending cmdReg", cmdReg, 11'h255);
    chk("R5 pending words", respWords, expWords);
    @(negedge clk);
    chk("R5 flag one cycle", unsupFlag, 0);
    chk("R5 pending status", status, expStat);

    // write while busy is ignored
    @(negedge clk); cmdWrEn = 1; cmdWrData = {1'b1, 4'b0001, 6'd30};
    @(negedge clk); cmdWrData = {1'b1, 4'b0000, 6'd31};
    @(negedge clk); cmdWrEn = 0;
    chk("R4 busy cmdReg", cmdReg, 11'h05E);
    chk("R4 busy index", reqIndex, 6'd30);
    reqReady = 1; @(negedge clk); reqReady = 0;
    rspValid = 1; rspLen = 4; rspData = pat; @(negedge clk); rspValid = 0;
    expStat[6] = 1; expWords = packWords(pat, 4);
    chk("R4 single completion", {status, reqValid}, {expStat, 1'b0});

    for (int n = 0; n < 300; n++) begin
      int lens[5] = '{0, 3, 4, 8, 16};
      logic [127:0] d;
      d = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 2) clearStat(12'($urandom));
      runCmd(6'($urandom), 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
             $urandom, lens[$urandom % 5], d, ($urandom % 10) == 0,
             $urandom % 3, ($urandom % 8) == 0, 12'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule